// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Resolver

This block sits beside a processor bus and recognises the special address pattern that marks an interrupt acknowledge cycle in CPU space. When that pattern appears with the cycle strobe high, it latches the priority level being acknowledged from the low address bits. It then looks at up to eight interrupt sources. Each source presents a request level, a 4-bit arbitration number, an 8-bit vector and a flag that asks for autovectoring. Only sources whose request matches the acknowledged level compete, and they are resolved by arbitration-number contention.

The block ends the cycle in one of three ways, each with a one-cycle pulse. It can return the winner's vector together with a data-transfer acknowledge. It can signal an autovector, with the vector number derived from the level. Or it can raise a bus error that tells the processor to use the spurious vector. A bus-monitor counter bounds the wait when no source answers.

The termination pins are plain control outputs. They carry no handshake and no back-pressure: the processor takes each pulse in the cycle it appears. The strobe must stay high until a pulse is seen, and the address must stay stable while the strobe is high.

Top module: `iack_resolver`

## Requirements
- R1: A cycle is accepted only when the strobe is high and address bits 23..4 and bit 0 are all ones. Any other address gives no pulse for as long as that strobe assertion lasts.
- R2: The acknowledged level is address bits 3..1. A source contends only when its request level is nonzero and equals that level. Sources at other levels have no effect on the result.
- R3: Among contenders the largest arbitration number wins. When two contenders have equal numbers, the lower source index wins.
- R4: A winner with a nonzero arbitration number and a clear autovector flag gives one pulse on `dtack_o`, with `vec_o` equal to that source's vector. With contenders present at acceptance, the pulse is in the cycle after the second rising edge, counting the accepting edge as the first.
- R5: A winner with its autovector flag set gives one pulse on `autovec_o`, with `vec_o` = 24 + level. The timing is the same as in R4.
- R6: When contenders exist but the best arbitration number is 0, the block gives one pulse on `buserr_o` with `vec_o` = 24. The timing is the same as in R4.
- R7: While there are no contenders, the block waits and re-evaluates on every cycle, so a request that appears later is served one cycle after it appears. If none appears, `buserr_o` pulses with `vec_o` = 24 in the cycle after rising edge LIMIT+1, counting the accepting edge as edge 1.
- R8: At most one of the three termination outputs is high in any cycle. Each pulse lasts one cycle, and each strobe assertion gives at most one pulse. `vec_o` is 0 whenever no pulse is present.
- R9: If the strobe falls before the cycle ends, the cycle is dropped and gives no pulse.
- R10: During and after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strb_i | input | 1 | Bus cycle strobe |
| addr_i | input | 24 | Bus address |
| src_lvl_i | input | 24 | Request level per source, 3 bits each, source i at bits 3i+2..3i; 0 = no request |
| src_arb_i | input | 32 | Arbitration number per source, 4 bits each |
| src_vec_i | input | 64 | Vector per source, 8 bits each |
| src_av_i | input | 8 | Autovector request flag per source |
| dtack_o | output | 1 | Vector-supplied termination pulse |
| autovec_o | output | 1 | Autovector termination pulse |
| buserr_o | output | 1 | Spurious or timeout bus-error pulse |
| vec_o | output | 8 | Vector number qualified by a termination pulse |

## Verification
A wrong latched level or a faulty contender mask shows up as a wrong `vec_o` or as the wrong termination type, and it appears on the very pulse that ends the cycle. A resolver stuck in its waiting state shows up as a missing pulse, and then as a bus error that arrives LIMIT+1 edges late instead of two. A resolver that fails to return to idle shows up as a repeated pulse or a silent next cycle. The scoreboard checks the type, the vector and the exact cycle of every pulse, so each of these faults is reported in the cycle where the pulse is due.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_HOLD = 2'd2
  } iack_state_t;

  localparam int SPURIOUS_VEC = 24;
endpackage

// File: rtl/iack_decode.sv
module iack_decode #(
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [LVL_W-1:0]  lvl
);
  localparam int HI_W = ADDR_W - LVL_W - 1;

  assign hit = (&addr[ADDR_W-1:LVL_W+1]) & addr[0];
  assign lvl = addr[LVL_W:1];

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter #(
  parameter int N     = 8,
  parameter int LVL_W = 3,
  parameter int ARB_W = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [LVL_W-1:0]   lvl,
  input  logic [N*LVL_W-1:0] src_lvl,
  input  logic [N*ARB_W-1:0] src_arb,
  output logic               found,
  output logic               zero_win,
  output logic [IDX_W-1:0]   win_idx
);
  logic [N-1:0] contend;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_match
      assign contend[g] = (src_lvl[g*LVL_W +: LVL_W] != '0) &&
                          (src_lvl[g*LVL_W +: LVL_W] == lvl);
    end
  endgenerate

  logic [ARB_W-1:0] best;
  always_comb begin
    best    = '0;
    win_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (contend[i]) begin
        if (!found || src_arb[i*ARB_W +: ARB_W] > best) begin
          best    = src_arb[i*ARB_W +: ARB_W];
          win_idx = IDX_W'(i);
        end
        found = 1'b1;
      end
    end
    zero_win = found && (best == '0);
  end
endmodule

// File: rtl/iack_busmon.sv
module iack_busmon #(
  parameter int LIMIT = 16,
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign expired = run && (cnt == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/iack_resolver.sv
module iack_resolver #(
  parameter int N      = 8,
  parameter int ADDR_W = 24,
  parameter int LVL_W  = 3,
  parameter int ARB_W  = 4,
  parameter int VEC_W  = 8,
  parameter int LIMIT  = 16,
  parameter int CNT_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strb_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N*LVL_W-1:0] src_lvl_i,
  input  logic [N*ARB_W-1:0] src_arb_i,
  input  logic [N*VEC_W-1:0] src_vec_i,
  input  logic [N-1:0]       src_av_i,
  output logic               dtack_o,
  output logic               autovec_o,
  output logic               buserr_o,
  output logic [VEC_W-1:0]   vec_o
);
  import iack_pkg::*;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  iack_state_t      state;
  logic [LVL_W-1:0] lvl_q;
  logic             hit;
  logic [LVL_W-1:0] addr_lvl;
  logic             found, zero_win, expired;
  logic [IDX_W-1:0] win_idx;

  iack_decode #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_dec (
    .addr(addr_i), .hit(hit), .lvl(addr_lvl)
  );

  iack_arbiter #(.N(N), .LVL_W(LVL_W), .ARB_W(ARB_W)) u_arb (
    .lvl(lvl_q), .src_lvl(src_lvl_i), .src_arb(src_arb_i),
    .found(found), .zero_win(zero_win), .win_idx(win_idx)
  );

  iack_busmon #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .run(state == ST_ARB && strb_i),
    .expired(expired)
  );

  logic [VEC_W-1:0] spur_vec, auto_vec, win_vec;
  assign spur_vec = VEC_W'(SPURIOUS_VEC);
  assign auto_vec = spur_vec + VEC_W'(lvl_q);
  assign win_vec  = src_vec_i[win_idx*VEC_W +: VEC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lvl_q     <= '0;
      dtack_o   <= 1'b0;
      autovec_o <= 1'b0;
      buserr_o  <= 1'b0;
      vec_o     <= '0;
    end else begin
      dtack_o   <= 1'b0;
      autovec_o <= 1'b0;
      buserr_o  <= 1'b0;
      vec_o     <= '0;
      case (state)
        ST_IDLE: if (strb_i && hit) begin
          state <= ST_ARB;
          lvl_q <= addr_lvl;
        end
        ST_ARB: begin
          if (!strb_i) begin
            state <= ST_IDLE;
          end else if (found) begin
            state <= ST_HOLD;
            if (zero_win) begin
              buserr_o <= 1'b1;
              vec_o    <= spur_vec;
            end else if (src_av_i[win_idx]) begin
              autovec_o <= 1'b1;
              vec_o     <= auto_vec;
            end else begin
              dtack_o <= 1'b1;
              vec_o   <= win_vec;
            end
          end else if (expired) begin
            state    <= ST_HOLD;
            buserr_o <= 1'b1;
            vec_o    <= spur_vec;
          end
        end
        default: if (!strb_i) state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/iack_resolver_chk.sv
module iack_resolver_chk #(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 8,
  parameter int LIMIT  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strb_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              dtack_o,
  input logic              autovec_o,
  input logic              buserr_o,
  input logic [VEC_W-1:0]  vec_o
);
  logic term, done, is_iack;
  logic [7:0] wait_cnt;
  assign term    = dtack_o | autovec_o | buserr_o;
  assign is_iack = (&addr_i[ADDR_W-1:4]) & addr_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; wait_cnt <= '0;
    end else if (!strb_i) begin
      done <= 1'b0; wait_cnt <= '0;
    end else begin
      if (term) done <= 1'b1;
      if (!done && !term && is_iack) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  AST_ONE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dtack_o, autovec_o, buserr_o}) <= 1);              // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> !term);                                              // R8
  AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !term |-> vec_o == '0);                                       // R8
  AST_ONCE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !term);                                              // R8
  AST_AUTO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    autovec_o |-> (vec_o > VEC_W'(24) && vec_o <= VEC_W'(31)));   // R5
  AST_SPUR_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    buserr_o |-> vec_o == VEC_W'(24));                            // R6
  AST_TERM_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    term |-> $past(strb_i));                                      // R9
  AST_BOUNDED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= 8'(LIMIT + 2));                                   // R7
endmodule

bind iack_resolver iack_resolver_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb_i(strb_i), .addr_i(addr_i),
  .dtack_o(dtack_o), .autovec_o(autovec_o), .buserr_o(buserr_o), .vec_o(vec_o)
);

// File: tb/sim_iack_resolver.sv
module sim_iack_resolver;
  localparam int N = 8;
  localparam int LIMIT = 16;

  logic clk = 0, rst_n = 0, strb = 0;
  logic [23:0] addr = '0;
  logic [N*3-1:0] s_lvl = '0;
  logic [N*4-1:0] s_arb = '0;
  logic [N*8-1:0] s_vec = '0;
  logic [N-1:0]   s_av  = '0;
  logic dtack, avec, berr;
  logic [7:0] vec;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  int q_kind[$], q_vec[$], q_due[$];
  string q_req[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iack_resolver #(.N(N), .LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .strb_i(strb), .addr_i(addr),
    .src_lvl_i(s_lvl), .src_arb_i(s_arb), .src_vec_i(s_vec), .src_av_i(s_av),
    .dtack_o(dtack), .autovec_o(avec), .buserr_o(berr), .vec_o(vec)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected terminations and compares type, vector, cycle
  always @(negedge clk) if (rst_n) begin
    int kind;
    kind = dtack ? 1 : avec ? 2 : berr ? 3 : 0;
    if (dtack + avec + berr > 1) chk("R8 multiple terminations", dtack + avec + berr, 1);
    if (kind != 0) begin
      pulses++;
      if (q_kind.size() == 0) chk("R8 unexpected pulse", kind, 0);
      else begin
        string r = q_req.pop_front();
        chk({r, " kind"}, kind, q_kind.pop_front());
        chk({r, " vector"}, vec, q_vec.pop_front());
        chk({r, " cycle"}, cyc, q_due.pop_front());
      end
    end else if (vec != 0) chk("R8 vec idle", vec, 0);
  end

  task automatic set_src(int i, int l, int a, int v, bit av);
    s_lvl[i*3 +: 3] = 3'(l);
    s_arb[i*4 +: 4] = 4'(a);
    s_vec[i*8 +: 8] = 8'(v);
    s_av[i] = av;
  endtask

  task automatic clear_src();
    s_lvl = '0; s_arb = '0; s_vec = '0; s_av = '0;
  endtask

  // driver: raises strobe, pushes expected item (kind 0 = none)
  task automatic run(string req, logic [23:0] a, int kind, int v, int lat, int hold);
    @(negedge clk);
    addr = a; strb = 1;
    if (kind != 0) begin
      q_req.push_back(req); q_kind.push_back(kind);
      q_vec.push_back(v); q_due.push_back(cyc + lat);
    end
    repeat (hold) @(negedge clk);
    strb = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [23:0] iack(int l);
    return 24'hFFFFF1 | 24'(l << 1);
  endfunction

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk("R10 reset dtack", dtack, 0);
    chk("R10 reset autovec", avec, 0);
    chk("R10 reset buserr", berr, 0);
    chk("R10 reset vec", vec, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 single vectored winner
    set_src(2, 5, 7, 8'h40, 0);
    run("R4 vectored", iack(5), 1, 8'h40, 2, 4);

    // R3 highest number wins; R2 other level ignored
    set_src(1, 5, 9, 8'h51, 0);
    set_src(6, 5, 12, 8'h66, 0);
    set_src(3, 4, 15, 8'h33, 0);
    run("R3 highest", iack(5), 1, 8'h66, 2, 4);
    run("R2 level four", iack(4), 1, 8'h33, 2, 4);

    // R3 tie -> lower index
    set_src(6, 5, 9, 8'h66, 0);
    run("R3 tie", iack(5), 1, 8'h51, 2, 4);

    // R5 autovector
    s_av[1] = 1;
    run("R5 autovector", iack(5), 2, 24 + 5, 2, 4);
    s_av[1] = 0;

    // R6 all contenders zero
    clear_src();
    set_src(0, 3, 0, 8'h10, 0);
    set_src(7, 3, 0, 8'h17, 0);
    run("R6 spurious", iack(3), 3, 24, 2, 4);

    // R1 near-miss addresses ignored
    set_src(5, 3, 6, 8'h35, 0);
    p0 = pulses;
    run("R1 bit0", iack(3) & 24'hFFFFFE, 0, 0, 0, 6);
    run("R1 bit18", iack(3) & 24'hFBFFFF, 0, 0, 0, 6);
    run("R1 bit8", iack(3) & 24'hFFFEFF, 0, 0, 0, 6);
    chk("R1 no pulse on non-acknowledge", pulses - p0, 0);

    // R8 long strobe gives one pulse
    p0 = pulses;
    run("R8 long hold", iack(3), 1, 8'h35, 2, 12);
    chk("R8 one pulse per strobe", pulses - p0, 1);

    // R7 timeout with no contenders
    clear_src();
    run("R7 timeout", iack(2), 3, 24, LIMIT + 1, LIMIT + 4);

    // R7 late request
    @(negedge clk);
    addr = iack(2); strb = 1;
    repeat (5) @(negedge clk);
    set_src(4, 2, 3, 8'h77, 0);
    q_req.push_back("R7 late request"); q_kind.push_back(1);
    q_vec.push_back(8'h77); q_due.push_back(cyc + 1);
    repeat (4) @(negedge clk);
    strb = 0;
    repeat (3) @(negedge clk);

    // R9 strobe dropped early
    clear_src();
    p0 = pulses;
    run("R9 abort", iack(6), 0, 0, 0, 3);
    set_src(4, 6, 2, 8'h64, 0);
    repeat (LIMIT + 4) @(negedge clk);
    chk("R9 no pulse after abort", pulses - p0, 0);
    run("R9 next cycle served", iack(6), 1, 8'h64, 2, 4);

    chk("R8 scoreboard drained", q_kind.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule